// File: doc/BRIEF.md
# Byte-Readable Event Counter Bank

This block is a bank of 16-bit event counters for monitoring. Each counter has its own event input and adds at most one per clock. The counters are read and written one byte at a time over an 8-bit processor bus. Each counter has two byte addresses. A read of the low byte also takes a copy of the high byte. The following read of the high byte returns that copy, so the two bytes always belong to the same count.

A global mode bit selects one of two counting modes:
- **Saturating mode.** A counter stops at its maximum. A read of the low byte clears the counter. An event that arrives in the same cycle as the clearing read is not lost: it is counted after the clear.
- **Rollover mode.** A counter wraps to zero after its maximum. Reads leave the count unchanged.

There are two ways to clear counters:
- A self-clearing command bit clears the whole bank at once.
- A single counter is cleared by a zero write to its low byte, followed at once by a zero write to its high byte.

Alarm inputs gate counting. The general counters pause while any alarm is raised. The two framing-error counters ignore the alarms and pause only while their own frame-loss input is raised.

Top module: `perf_counter_bank`

## Requirements
- R1: After a synchronous active-high reset:
  - every counter reads 0x0000;
  - the mode register at 0x13 reads 0x00;
  - bus_rdata is 0x00.
- R2: With no inhibit active, each cycle with evt_in[k] high adds one to counter k. Counter k has its low byte at address 2k and its high byte at 2k+1.
- R3: A read of address 2k returns bits 7:0 of counter k and captures bits 15:8. A following read of 2k+1 returns the captured byte, even if the counter has changed in between.
- R4: When bit 0 of register 0x13 is 0 (saturating), a counter at 0xFFFF stays at 0xFFFF as events arrive.
- R5: In saturating mode, a read of address 2k clears counter k. An event on evt_in[k] in the cycle of that read is counted, so the counter then reads 1.
- R6: When bit 0 of register 0x13 is 1 (rollover):
  - a counter at 0xFFFF goes to 0x0000 on its next event;
  - reads do not change any counter.
- R7: Writing a byte with bit 7 set to address 0x1C clears every counter in the same cycle. Address 0x1C always reads 0x00.
- R8: Writing 0x00 to address 2k, and then 0x00 to 2k+1 as the next bus access, clears counter k and leaves the other counters unchanged.
- R9: A zero write to 2k is cancelled, and no counter is cleared, when the next bus access is any of:
  - a read;
  - a nonzero write;
  - a write to an address other than 2k+1.
  Nonzero writes to counter addresses have no effect.
- R10: Counters 2 and up ignore their events while any bit of alarm_in is high.
- R11: Counters 0 and 1 ignore alarm_in. Counter k (k<2) ignores its events only while frame_loss_in[k] is high.
- R12: Read data appears on bus_rdata in the cycle after the bus_rd strobe, and is 0x00 in cycles with no read. Register 0x13 reads back the mode bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_in | input | 4 | Per-counter event pulses |
| alarm_in | input | 4 | General inhibit alarms |
| frame_loss_in | input | 2 | Frame-loss inhibits for counters 0 and 1 |

## Verification
The bench goes after the corner cases below, and names the failure a faulty design would show for each:
- **Snapshot.** The counter is carried from 0x00FF to 0x0100 between the two byte reads. A design without the snapshot returns 0x01 for the high byte.
- **Event during a clearing read.** An event lands in the cycle of the clearing read. A design that drops it reads 0 instead of 1 afterwards.
- **Limits.** The bank is driven to its limit and one step past it in both modes:
  - a saturating design that wraps shows 0x0000;
  - a rollover design that saturates shows 0xFFFF.
- **Single clear.** Three broken zero-write pairs are applied: a read in between, a nonzero second byte, and the wrong address. A decoder that ignores the next-access rule clears the counter.
- **Alarm sweep.** The sweep covers every alarm pattern with every frame-loss pattern. Gating with the wrong inhibit produces the wrong count.

// File: rtl/perf_bank_pkg.sv
package perf_bank_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] bus_byte_t;
   typedef enum logic [1:0] {ACC_IDLE, ACC_READ, ACC_WRITE} bus_acc_e;

   function automatic bus_acc_e classify(input logic rd, input logic wr);
      if (rd)      return ACC_READ;
      else if (wr) return ACC_WRITE;
      return ACC_IDLE;
   endfunction
endpackage

// File: rtl/perf_inhibit_gate.sv
module perf_inhibit_gate #(
   parameter int NUM_CTRS    = 4,
   parameter int NUM_FRAMING = 2,
   parameter int NUM_ALARMS  = 4
) (
   input  logic [NUM_ALARMS-1:0]  alarm_in,
   input  logic [NUM_FRAMING-1:0] frame_loss_in,
   output logic [NUM_CTRS-1:0]    inhibit
);
   logic any_alarm;
   assign any_alarm = |alarm_in;

   for (genvar k = 0; k < NUM_CTRS; k++) begin : g_inh
      if (k < NUM_FRAMING) begin : g_frm
         assign inhibit[k] = frame_loss_in[k];
      end else begin : g_gen
         assign inhibit[k] = any_alarm;
      end
   end
endmodule

// File: rtl/perf_ctr_cell.sv
module perf_ctr_cell #(
   parameter int CTR_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              evt,
   input  logic              inhibit,
   input  logic              roll_mode,
   input  logic              rd_clear,
   input  logic              snap_en,
   input  logic              clear,
   output logic [CTR_W-1:0]  value,
   output logic [CTR_W-9:0]  snap_hi
);
   localparam int HI_W = CTR_W - 8;
   localparam logic [CTR_W-1:0] MAX_V = {CTR_W{1'b1}};

   logic [CTR_W-1:0] cnt_q;
   logic             held_q;
   logic [HI_W-1:0]  snap_q;
   logic             evt_ok;

   function automatic logic [CTR_W-1:0] bump(input logic [CTR_W-1:0] a,
                                             input logic b, input logic roll);
      logic [CTR_W:0] s;
      s = {1'b0, a} + {{CTR_W{1'b0}}, b};
      if (!roll && s[CTR_W]) return MAX_V;
      return s[CTR_W-1:0];
   endfunction

   assign evt_ok  = evt && !inhibit;
   assign value   = bump(cnt_q, held_q, roll_mode);
   assign snap_hi = snap_q;

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         cnt_q  <= '0;
         held_q <= 1'b0;
      end else if (rd_clear) begin
         cnt_q  <= '0;
         held_q <= evt_ok;
      end else begin
         cnt_q  <= bump(value, evt_ok, roll_mode);
         held_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clear)  snap_q <= '0;
      else if (snap_en)  snap_q <= value[CTR_W-1:8];
   end

   // R4
   sat_stop_chk: assert property (@(posedge clk) disable iff (rst)
      (!roll_mode && value == MAX_V && !clear && !rd_clear) |=> (value == MAX_V));
   // R5
   hold_add_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_clear && evt_ok && !clear) |=> (value == CTR_W'(1)));
   // R6
   wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (roll_mode && value == MAX_V && evt_ok && !clear && !rd_clear) |=> (value == '0));
   // R10
   inhib_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (inhibit && !clear && !rd_clear) |=> (value == $past(value)));
   // R8
   clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
      clear |=> (value == '0));
endmodule

// File: rtl/perf_bus_front.sv
module perf_bus_front
   import perf_bank_pkg::*;
#(
   parameter int NUM_CTRS  = 4,
   parameter int CTR_W     = 16,
   parameter int ADDR_W    = 8,
   parameter int MODE_ADDR = 8'h13,
   parameter int BULK_ADDR = 8'h1C,
   parameter int BULK_BIT  = 7
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          bus_rd,
   input  logic                          bus_wr,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  bus_byte_t                     bus_wdata,
   output bus_byte_t                     bus_rdata,
   input  logic [NUM_CTRS-1:0][CTR_W-1:0] values,
   input  logic [NUM_CTRS-1:0][CTR_W-9:0] snaps,
   output logic                          roll_mode,
   output logic [NUM_CTRS-1:0]           rd_clear,
   output logic [NUM_CTRS-1:0]           snap_en,
   output logic [NUM_CTRS-1:0]           clear
);
   localparam int IDX_W    = $clog2(NUM_CTRS);
   localparam int CTR_SPAN = 2 * NUM_CTRS;

   bus_acc_e          acc;
   logic              in_ctr;
   logic [IDX_W-1:0]  idx;
   logic              is_low;
   logic              wzero;
   logic              bulk_clr;
   logic              pend_q;
   logic [IDX_W-1:0]  pend_idx_q;
   logic              mode_q;
   bus_byte_t         rd_mux;

   assign acc      = classify(bus_rd, bus_wr);
   assign in_ctr   = bus_addr < ADDR_W'(CTR_SPAN);
   assign idx      = bus_addr[IDX_W:1];
   assign is_low   = !bus_addr[0];
   assign wzero    = (acc == ACC_WRITE) && (bus_wdata == '0);
   assign bulk_clr = (acc == ACC_WRITE) && (bus_addr == ADDR_W'(BULK_ADDR))
                     && bus_wdata[BULK_BIT];
   assign roll_mode = mode_q;

   for (genvar k = 0; k < NUM_CTRS; k++) begin : g_strb
      logic hit;
      assign hit         = in_ctr && (idx == IDX_W'(k));
      assign snap_en[k]  = (acc == ACC_READ) && hit && is_low;
      assign rd_clear[k] = snap_en[k] && !mode_q;
      assign clear[k]    = bulk_clr ||
                           (pend_q && wzero && hit && !is_low && pend_idx_q == IDX_W'(k));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q     <= 1'b0;
         pend_idx_q <= '0;
      end else if (acc != ACC_IDLE) begin
         pend_q     <= wzero && in_ctr && is_low;
         pend_idx_q <= idx;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) mode_q <= 1'b0;
      else if (acc == ACC_WRITE && bus_addr == ADDR_W'(MODE_ADDR))
         mode_q <= bus_wdata[0];
   end

   always_comb begin
      rd_mux = '0;
      if (in_ctr) begin
         if (is_low) rd_mux = values[idx][7:0];
         else        rd_mux = BYTE_W'(snaps[idx]);
      end else if (bus_addr == ADDR_W'(MODE_ADDR)) begin
         rd_mux = {{(BYTE_W-1){1'b0}}, mode_q};
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                  bus_rdata <= '0;
      else if (acc == ACC_READ) bus_rdata <= rd_mux;
      else                      bus_rdata <= '0;
   end

   // R7
   bulk_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == ADDR_W'(BULK_ADDR)) |=> (bus_rdata == '0));
   // R12
   rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !bus_rd |=> (bus_rdata == '0));
   // R12
   single_access_chk: assert property (@(posedge clk) disable iff (rst)
      !(bus_rd && bus_wr));
   // R9
   clear_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
      (|clear && !bulk_clr) |-> pend_q);
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
   parameter int NUM_CTRS    = 4,
   parameter int CTR_W       = 16,
   parameter int NUM_FRAMING = 2,
   parameter int NUM_ALARMS  = 4,
   parameter int ADDR_W      = 8,
   parameter int MODE_ADDR   = 8'h13,
   parameter int BULK_ADDR   = 8'h1C
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   bus_rd,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [7:0]             bus_wdata,
   output logic [7:0]             bus_rdata,
   input  logic [NUM_CTRS-1:0]    evt_in,
   input  logic [NUM_ALARMS-1:0]  alarm_in,
   input  logic [NUM_FRAMING-1:0] frame_loss_in
);
   if (CTR_W <= 8 || CTR_W > 16) begin : g_bad_w
      $error("CTR_W must be 9..16");
   end
   if (NUM_CTRS < 2 || NUM_FRAMING > NUM_CTRS || NUM_FRAMING < 1) begin : g_bad_n
      $error("counter counts out of range");
   end
   if (2 * NUM_CTRS > MODE_ADDR || 2 * NUM_CTRS > BULK_ADDR || MODE_ADDR == BULK_ADDR) begin : g_bad_map
      $error("register addresses overlap counter space");
   end

   logic [NUM_CTRS-1:0][CTR_W-1:0] values;
   logic [NUM_CTRS-1:0][CTR_W-9:0] snaps;
   logic [NUM_CTRS-1:0]            inhibit, rd_clear, snap_en, clear;
   logic                           roll_mode;

   perf_inhibit_gate #(
      .NUM_CTRS(NUM_CTRS), .NUM_FRAMING(NUM_FRAMING), .NUM_ALARMS(NUM_ALARMS)
   ) u_gate (
      .alarm_in(alarm_in), .frame_loss_in(frame_loss_in), .inhibit(inhibit)
   );

   perf_bus_front #(
      .NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W), .ADDR_W(ADDR_W),
      .MODE_ADDR(MODE_ADDR), .BULK_ADDR(BULK_ADDR), .BULK_BIT(7)
   ) u_front (
      .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .values(values), .snaps(snaps), .roll_mode(roll_mode),
      .rd_clear(rd_clear), .snap_en(snap_en), .clear(clear)
   );

   for (genvar k = 0; k < NUM_CTRS; k++) begin : g_ctr
      perf_ctr_cell #(.CTR_W(CTR_W)) u_cell (
         .clk(clk), .rst(rst), .evt(evt_in[k]), .inhibit(inhibit[k]),
         .roll_mode(roll_mode), .rd_clear(rd_clear[k]), .snap_en(snap_en[k]),
         .clear(clear[k]), .value(values[k]), .snap_hi(snaps[k])
      );
   end
endmodule

// File: tb/perf_counter_bank_test.sv
module perf_counter_bank_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [3:0] evt_in = '0, alarm_in = '0;
   logic [1:0] frame_loss_in = '0;
   int nchk = 0, nfail = 0;

   always #5 clk = ~clk;

   perf_counter_bank uut (
      .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_in(evt_in), .alarm_in(alarm_in), .frame_loss_in(frame_loss_in)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic rd_byte(input logic [7:0] a, input logic [3:0] ev, output logic [7:0] d);
      bus_rd = 1'b1; bus_addr = a; evt_in = ev;
      @(negedge clk);
      d = bus_rdata;
      bus_rd = 1'b0; evt_in = '0;
      @(negedge clk);
   endtask

   task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
      @(negedge clk);
   endtask

   task automatic rd_ctr(input int k, output logic [15:0] v);
      logic [7:0] lo, hi;
      rd_byte(8'(2 * k), 4'h0, lo);
      rd_byte(8'(2 * k + 1), 4'h0, hi);
      v = {hi, lo};
   endtask

   task automatic run(input logic [3:0] m, input int n);
      for (int i = 0; i < n; i++) begin
         evt_in = m;
         @(negedge clk);
      end
      evt_in = '0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nfail++;
      $display("FAIL R2: watchdog expired, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [7:0]  b;
      repeat (3) @(negedge clk);
      check("R1 rdata after reset", bus_rdata, 0);
      rst = 1'b0;
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin rd_ctr(k, v); check("R1 counter reset", v, 0); end
      rd_byte(8'h13, 4'h0, b); check("R1 mode reset", b, 0);
      rd_byte(8'h1C, 4'h0, b); check("R7 bulk reg reads 0", b, 0);

      // R2: every event mask once, each counter sees 8
      for (int m = 0; m < 16; m++) run(4'(m), 1);
      for (int k = 0; k < 4; k++) begin rd_ctr(k, v); check("R2 mask sweep", v, 8); end

      // R10 R11: all alarm and frame-loss patterns
      for (int a = 0; a < 16; a++)
         for (int f = 0; f < 4; f++) begin
            alarm_in = 4'(a); frame_loss_in = 2'(f);
            run(4'hF, 1);
         end
      alarm_in = '0; frame_loss_in = '0;
      rd_ctr(0, v); check("R11 framing ctr0", v, 32);
      rd_ctr(1, v); check("R11 framing ctr1", v, 32);
      rd_ctr(2, v); check("R10 general ctr2", v, 4);
      rd_ctr(3, v); check("R10 general ctr3", v, 4);
      for (int k = 0; k < 4; k++) begin rd_ctr(k, v); check("R5 cleared by read", v, 0); end

      // R3 snapshot across 0x00FF -> 0x0100, in rollover mode
      wr_byte(8'h13, 8'h01);
      rd_byte(8'h13, 4'h0, b); check("R12 mode readback", b, 1);
      run(4'h1, 255);
      rd_byte(8'h00, 4'h0, b); check("R3 low byte", b, 8'hFF);
      run(4'h1, 1);
      rd_byte(8'h01, 4'h0, b); check("R3 frozen high byte", b, 8'h00);
      rd_ctr(0, v); check("R6 read does not clear", v, 16'h0100);

      // R5 event during clearing read
      wr_byte(8'h13, 8'h00);
      run(4'h2, 5);
      rd_byte(8'h02, 4'h2, b); check("R5 read value", b, 5);
      rd_ctr(1, v); check("R5 held event counted", v, 1);

      // R7 bulk clear
      wr_byte(8'h1C, 8'h80);
      rd_byte(8'h1C, 4'h0, b); check("R7 self-clearing bit", b, 0);
      rd_ctr(0, v); check("R7 bulk clear ctr0", v, 0);

      // R4 saturation
      run(4'hF, 65538);
      rd_ctr(2, v); check("R4 saturated ctr2", v, 16'hFFFF);
      wr_byte(8'h13, 8'h01);
      run(4'h8, 1);
      rd_ctr(3, v); check("R6 wrap ctr3", v, 0);
      rd_ctr(2, v); check("R5 sat read cleared ctr2", v, 0);

      // R8 single clear
      wr_byte(8'h00, 8'h00); wr_byte(8'h01, 8'h00);
      rd_ctr(0, v); check("R8 ctr0 cleared", v, 0);
      rd_ctr(1, v); check("R8 ctr1 untouched", v, 16'hFFFF);
      // R9 broken pairs
      wr_byte(8'h02, 8'h00); rd_byte(8'h13, 4'h0, b); wr_byte(8'h03, 8'h00);
      rd_ctr(1, v); check("R9 read in between", v, 16'hFFFF);
      wr_byte(8'h02, 8'h00); wr_byte(8'h03, 8'h05);
      rd_ctr(1, v); check("R9 nonzero second byte", v, 16'hFFFF);
      wr_byte(8'h02, 8'h00); wr_byte(8'h01, 8'h00);
      rd_ctr(1, v); check("R9 wrong address", v, 16'hFFFF);
      wr_byte(8'h02, 8'h37);
      rd_ctr(1, v); check("R9 nonzero write ignored", v, 16'hFFFF);

      wr_byte(8'h1C, 8'h80);
      rd_ctr(1, v); check("R7 bulk clear ctr1", v, 0);
      @(negedge clk);
      check("R12 rdata idle", bus_rdata, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule